// File: doc/BRIEF.md
# Waveform Memory Address Generator

This block produces the read address for a 64K-entry waveform sample memory. It has two modes. In stepping mode, an address counter advances by one on each cycle where the sample-enable input is high. After the last point of a waveform whose length is programmable, the counter returns to zero. The waveform's repetition rate is therefore the sample rate divided by its length. In phase mode, a 38-bit phase accumulator adds a stored increment on every clock. The top 12 bits of the accumulator index a 4096-point single-cycle table, so the output frequency is proportional to the increment.

Both outputs come straight from registers and are always valid. There is no handshake: the memory downstream reads `addr_o` on every cycle and cannot apply back-pressure. A one-cycle marker, `cyc_start_o`, flags the cycle in which the address has just wrapped to the start of a waveform period. A controller can sweep the output frequency by reloading the increment while the block runs. The new value is used from the accumulation after the load.

Top module: `wag_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `addr_o` is 0, `cyc_start_o` is 0, the stored increment is 0 and the mode in force is stepping.
- R2: In stepping mode (`mode_i`=0), each clock edge with `sample_en_i`=1 changes the address to the previous address plus one. If the address is at or beyond the last point (effective length minus 1), the address returns to 0 instead.
- R3: In stepping mode, an edge with `sample_en_i`=0 leaves the address unchanged and produces no cycle-start marker.
- R4: The effective length is derived from `len_i` as follows:
  - A value of 2 is used as is.
  - Values 0, 1 and 3 are raised to 4.
  - Values above 65536 are limited to 65536.
  - All other values are used as given.
  
  If the length is shortened while the counter is beyond the new last point, the next enabled step returns the address to 0.
- R5: In phase mode (`mode_i`=1), every clock edge adds the stored increment to the accumulator modulo 2^38, whatever the state of `sample_en_i`. `addr_o[11:0]` equals accumulator bits [37:26].
- R6: In phase mode, `addr_o[15:12]` is always 0.
- R7: An edge with `inc_load_i`=1 stores `phase_inc_i`. That same edge still accumulates with the previous increment, and the new increment is used from the following edge. When `inc_load_i`=0, `phase_inc_i` has no effect.
- R8: On the edge where `mode_i` differs from the mode in force, the new mode takes over, the counter and the accumulator are cleared, and `cyc_start_o` is 0 in the next cycle. The stored increment is kept.
- R9: In stepping mode, `cyc_start_o` is high for exactly the one cycle in which the address has just returned to 0 after the last point.
- R10: In phase mode, `cyc_start_o` is high for the cycle after an accumulation whose sum reached or passed 2^38. At such a point the address does not increase; at every other point it does not decrease.
- R11: Starting from a cleared accumulator with increment K, the number of cycle-start markers over N clocks equals floor(N·K/2^38). With a clock of 2^38·10^-4 Hz, K is therefore the output frequency in units of 0.1 mHz. An increment of 2^26 advances the address by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = stepping mode, 1 = phase mode |
| len_i | input | 17 | Waveform length in points for stepping mode |
| phase_inc_i | input | 38 | Phase increment value |
| inc_load_i | input | 1 | Stores `phase_inc_i` on this edge |
| sample_en_i | input | 1 | Advances the counter in stepping mode |
| addr_o | output | 16 | Sample memory read address |
| cyc_start_o | output | 1 | Address has just wrapped to a new period |

## Verification
The hardest state to reach is an accumulator carry landing exactly on chosen cycles. This matters for checking that cycle-start markers and skipped or repeated addresses track the increment. The stimulus uses an increment of three quarters of a turn, so carries occur on three consecutive edges and the addresses step backwards through the table. It uses 2^26 to walk every address once up to the first rollover. It also uses an irregular increment over 20000 clocks, where the marker count and the final address are predicted from exact integer arithmetic. A mid-run increment reload, and shortening the length below the live count, each check an ordering at one precise edge.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic {
    WAG_STEP  = 1'b0,
    WAG_PHASE = 1'b1
  } wag_mode_e;
endpackage

// File: rtl/wag_len_clamp.sv
// Turns the programmed length into the index of the last point.
module wag_len_clamp #(
  parameter int ADDR_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int SQ_LEN  = 2
) (
  input  logic [ADDR_W:0]   len_raw,
  output logic [ADDR_W-1:0] last_pt
);
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << ADDR_W;
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] SQ_L    = LEN_W'(SQ_LEN);

  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] eff_m1;

  always_comb begin
    if (len_raw > MAX_LEN)                         eff_len = MAX_LEN;
    else if (len_raw == SQ_L)                      eff_len = SQ_L;
    else if (len_raw < MIN_L)                      eff_len = MIN_L;
    else                                           eff_len = len_raw;
    eff_m1 = eff_len - LEN_W'(1);
  end

  assign last_pt = eff_m1[ADDR_W-1:0];
endmodule

// File: rtl/wag_seq_counter.sv
// Point counter for stepping mode with a registered wrap marker.
module wag_seq_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [ADDR_W-1:0] last_pt,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] cnt_q;
  logic              wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (step) begin
      if (cnt_q >= last_pt) begin
        cnt_q  <= '0;
        wrap_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + ADDR_W'(1);
        wrap_q <= 1'b0;
      end
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/wag_phase_acc.sv
// Phase accumulator with its own increment register.
module wag_phase_acc #(
  parameter int ACC_W    = 38,
  parameter int TBL_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                run,
  input  logic                inc_load,
  input  logic [ACC_W-1:0]    inc_in,
  output logic [TBL_BITS-1:0] phase_top_o,
  output logic                wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_q;
  logic             wrap_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= '0;
    end else if (inc_load) begin
      inc_q <= inc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else if (run) begin
      acc_q  <= sum[ACC_W-1:0];
      wrap_q <= sum[ACC_W];
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign phase_top_o = acc_q[ACC_W-1 -: TBL_BITS];
  assign wrap_o      = wrap_q;
endmodule

// File: rtl/wag_addr_gen.sv
module wag_addr_gen
  import wag_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ACC_W    = 38,
  parameter int TBL_BITS = 12,
  parameter int MIN_LEN  = 4,
  parameter int SQ_LEN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic [ACC_W-1:0]  phase_inc_i,
  input  logic              inc_load_i,
  input  logic              sample_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cyc_start_o
);
  localparam int PAD_W = ADDR_W - TBL_BITS;

  wag_mode_e             mode_q;
  wag_mode_e             mode_req;
  logic                  mode_chg;
  logic [ADDR_W-1:0]     last_pt;
  logic [ADDR_W-1:0]     seq_addr;
  logic                  seq_wrap;
  logic [TBL_BITS-1:0]   phase_top;
  logic                  phase_wrap;
  logic [ADDR_W-1:0]     phase_addr;

  assign mode_req = wag_mode_e'(mode_i);
  assign mode_chg = (mode_req != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WAG_STEP;
    else        mode_q <= mode_req;
  end

  wag_len_clamp #(
    .ADDR_W (ADDR_W),
    .MIN_LEN(MIN_LEN),
    .SQ_LEN (SQ_LEN)
  ) u_clamp (
    .len_raw(len_i),
    .last_pt(last_pt)
  );

  wag_seq_counter #(
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mode_chg),
    .step   (sample_en_i && mode_q == WAG_STEP),
    .last_pt(last_pt),
    .cnt_o  (seq_addr),
    .wrap_o (seq_wrap)
  );

  wag_phase_acc #(
    .ACC_W   (ACC_W),
    .TBL_BITS(TBL_BITS)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (mode_chg),
    .run        (mode_q == WAG_PHASE),
    .inc_load   (inc_load_i),
    .inc_in     (phase_inc_i),
    .phase_top_o(phase_top),
    .wrap_o     (phase_wrap)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign phase_addr = {{PAD_W{1'b0}}, phase_top};
    end else begin : g_nopad
      assign phase_addr = phase_top[ADDR_W-1:0];
    end
  endgenerate

  assign addr_o      = (mode_q == WAG_PHASE) ? phase_addr : seq_addr;
  assign cyc_start_o = (mode_q == WAG_PHASE) ? phase_wrap : seq_wrap;
endmodule

// File: rtl/wag_addr_gen_chk.sv
module wag_addr_gen_chk #(
  parameter int ADDR_W   = 16,
  parameter int TBL_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_i,
  input logic              sample_en_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cyc_start_o,
  input logic              mode_cur,
  input logic [ADDR_W-1:0] last_pt
);
  logic steady;
  assign steady = (mode_i == mode_cur);

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cur && steady && sample_en_i && addr_o < last_pt)
      |=> (addr_o == $past(addr_o) + ADDR_W'(1)) && !cyc_start_o);

  a_r9_wrap_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cur && steady && sample_en_i && addr_o >= last_pt)
      |=> (addr_o == '0) && cyc_start_o);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cur && steady && !sample_en_i)
      |=> $stable(addr_o) && !cyc_start_o);

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cur |-> (addr_o[ADDR_W-1:TBL_BITS] == '0));

  a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !steady |=> (addr_o == '0) && !cyc_start_o);

  a_r10_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur && steady)
      |=> (cyc_start_o ? (addr_o <= $past(addr_o)) : (addr_o >= $past(addr_o))));
endmodule

bind wag_addr_gen wag_addr_gen_chk #(
  .ADDR_W  (ADDR_W),
  .TBL_BITS(TBL_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .sample_en_i(sample_en_i),
  .addr_o     (addr_o),
  .cyc_start_o(cyc_start_o),
  .mode_cur   (mode_q),
  .last_pt    (last_pt)
);

// File: tb/test_wag_addr_gen.sv
module test_wag_addr_gen;
  localparam int ADDR_W = 16;
  localparam int ACC_W  = 38;
  localparam int NV     = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_i = 1'b0;
  logic [ADDR_W:0]   len_i = '0;
  logic [ACC_W-1:0]  phase_inc_i = '0;
  logic              inc_load_i = 1'b0;
  logic              sample_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              cyc_start_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wag_addr_gen i_wag_addr_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .len_i(len_i),
    .phase_inc_i(phase_inc_i), .inc_load_i(inc_load_i),
    .sample_en_i(sample_en_i), .addr_o(addr_o), .cyc_start_o(cyc_start_o)
  );

  // stepping-mode vectors: length, enabled steps from zero, final address, markers
  localparam int V_LEN  [NV] = '{4, 4, 2, 0, 3, 1, 100, 65536, 70000};
  localparam int V_STEP [NV] = '{3, 4, 5, 5, 4, 7, 250, 10, 5};
  localparam int V_ADDR [NV] = '{3, 0, 1, 1, 0, 3, 50, 10, 5};
  localparam int V_CYC  [NV] = '{0, 1, 2, 1, 1, 1, 2, 0, 0};

  // phase mode with three-quarter turn: addresses and markers after each edge
  localparam int Q_ADDR [5] = '{3072, 2048, 1024, 0, 3072};
  localparam int Q_CYC  [5] = '{0, 1, 1, 1, 0};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc_start_o) pulses++;
    end
  endtask

  task automatic do_reset();
    mode_i = 1'b0; inc_load_i = 1'b0; sample_en_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p;
    longint k, prod, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 addr after reset", addr_o, 0);
    chk("R1 marker after reset", cyc_start_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr after release", addr_o, 0);

    // R2 and R4: vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      len_i = (ADDR_W+1)'(V_LEN[v]);
      sample_en_i = 1'b1;
      run(V_STEP[v], p);
      sample_en_i = 1'b0;
      chk($sformatf("R2/R4 vector %0d addr", v), addr_o, V_ADDR[v]);
      chk($sformatf("R9 vector %0d markers", v), p, V_CYC[v]);
    end

    // R3: disabled steps hold the address
    do_reset();
    len_i = 8; sample_en_i = 1'b1;
    run(3, p);
    sample_en_i = 1'b0;
    run(5, p);
    chk("R3 hold addr", addr_o, 3);
    chk("R3 hold markers", p, 0);

    // R4: shorten length below live count
    do_reset();
    len_i = 100; sample_en_i = 1'b1;
    run(50, p);
    chk("R4 before shrink", addr_o, 50);
    len_i = 10;
    run(1, p);
    chk("R4 shrink returns to zero", addr_o, 0);
    chk("R9 shrink marker", cyc_start_o, 1);
    sample_en_i = 1'b0;

    // R1: increment cleared by reset
    do_reset();
    mode_i = 1'b1;
    run(6, p);
    chk("R1 increment cleared", addr_o, 0);

    // R5, R6, R7: unit step increment, sample enable low
    do_reset();
    mode_i = 1'b1; phase_inc_i = 38'd1 << 26; inc_load_i = 1'b1;
    run(1, p);
    inc_load_i = 1'b0;
    run(10, p);
    chk("R5 unit increment addr", addr_o, 10);
    phase_inc_i = 38'd1 << 27; inc_load_i = 1'b1;
    run(1, p);
    chk("R7 load edge uses old increment", addr_o, 11);
    inc_load_i = 1'b0; phase_inc_i = 38'd5;
    run(1, p);
    chk("R7 new increment after load", addr_o, 13);
    run(1, p);
    chk("R7 unloaded input ignored", addr_o, 15);

    // R10, R11: exact rollover with increment 2^26
    do_reset();
    mode_i = 1'b1; phase_inc_i = 38'd1 << 26; inc_load_i = 1'b1;
    run(1, p);
    inc_load_i = 1'b0;
    run(4095, p);
    chk("R11 last table point", addr_o, 4095);
    chk("R10 no marker before rollover", p, 0);
    run(1, p);
    chk("R10 rollover addr", addr_o, 0);
    chk("R10 rollover marker", cyc_start_o, 1);

    // R10, R6: three-quarter turn skips and repeated carries
    do_reset();
    mode_i = 1'b1; phase_inc_i = 38'd3 << 36; inc_load_i = 1'b1;
    run(1, p);
    inc_load_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      run(1, p);
      chk($sformatf("R10 skip addr %0d", i), addr_o, Q_ADDR[i]);
      chk($sformatf("R10 skip marker %0d", i), cyc_start_o, Q_CYC[i]);
      chk($sformatf("R6 upper bits %0d", i), addr_o[15:12], 0);
    end

    // R8: mode changes clear and keep the increment
    mode_i = 1'b0; len_i = 8; sample_en_i = 1'b1;
    run(1, p);
    chk("R8 clear into stepping", addr_o, 0);
    chk("R8 no marker on change", cyc_start_o, 0);
    run(3, p);
    chk("R8 stepping resumes", addr_o, 3);
    mode_i = 1'b1;
    run(1, p);
    chk("R8 clear into phase", addr_o, 0);
    run(1, p);
    chk("R8 increment kept", addr_o, 3072);
    sample_en_i = 1'b0;

    // R11: frequency relation over a long run
    do_reset();
    k = 64'd123456789; n = 20000;
    mode_i = 1'b1; phase_inc_i = k[ACC_W-1:0]; inc_load_i = 1'b1;
    run(1, p);
    inc_load_i = 1'b0;
    run(int'(n), p);
    prod = n * k;
    chk("R11 marker count", p, prod >> 38);
    chk("R11 final addr", addr_o, (prod & ((64'd1 << 38) - 1)) >> 26);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule